// File: doc/BRIEF.md
# Jump Resolution Unit

This unit settles the outcome of a jump instruction and advances the program counter. Each cycle it is given the four status flags (zero, carry, negative, overflow), a 4-bit condition selector, the sequential address (the PC already moved past the jump), and a target address. When the jump-valid input is high, the unit tests the selected condition against the flags. It loads the PC with the target if the condition holds, and with the sequential address if it does not. When jump-valid is low, the PC keeps its value.

The conditions are the unconditional jump, the eight single-flag tests, and the signed greater-or-equal / less-than pair built from N and V. After a compare of A minus B, the carry tests also serve as the unsigned higher-or-same and lower tests. Flag generation, decoding and call/return are handled elsewhere.

Top module: `jump_resolver`

## Requirements
- R1: In a cycle where synchronous active-low reset is sampled low, `pc_q` loads the parameter `RESET_VEC` at that clock edge.
- R2: While `jmp_valid` is 0, `taken` is 0 and `pc_q` keeps its value across the clock edge, whatever the other inputs are.
- R3: Selector code 0 (always) makes `taken` 1 whenever `jmp_valid` is 1.
- R4: Code 1 is taken when Z=1 (equal), code 2 when Z=0 (not equal).
- R5: Code 3 is taken when C=1 (unsigned higher-or-same), code 4 when C=0 (unsigned lower).
- R6: Code 5 is taken when N=1, code 6 when N=0.
- R7: Code 7 is taken when V=1, code 8 when V=0.
- R8: Code 9 (signed greater-or-equal) is taken when N equals V; code 10 (signed less-than) is taken when N differs from V.
- R9: Codes 11 to 15 are never taken.
- R10: With `jmp_valid` = 1, `pc_q` after the clock edge equals `jmp_target` if `taken` was 1 and `seq_pc` otherwise. `taken` and `next_pc` are combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jmp_valid | input | 1 | A jump is presented this cycle |
| jmp_cond | input | 4 | Condition selector code (see R3 to R9) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| seq_pc | input | ADDR_W | Address following the jump |
| jmp_target | input | ADDR_W | Jump destination |
| taken | output | 1 | Jump is taken this cycle |
| next_pc | output | ADDR_W | Value `pc_q` will load at the next edge |
| pc_q | output | ADDR_W | Registered program counter |

## Verification
The bench builds the unit with `ADDR_W` = 12 and `RESET_VEC` = 12'hA5C. The reset value is then distinct from every address the bench drives, so a missed reset or a stray load shows up. The narrow width keeps the target and sequential patterns short while still telling them apart. Every one of the 16 selector codes is run against all 16 flag combinations, which reaches each condition's true and false side and the unused codes. Hold cycles with jump-valid low are placed between jumps.

// File: rtl/jr_pkg.sv
// Package: shared types and the condition truth function for the jump
// resolution unit. Assumes a 4-bit selector; codes above JR_LAST are unused.
package jr_pkg;
    localparam int JR_COND_W = 4;
    localparam int JR_NCODES = 1 << JR_COND_W;

    typedef enum logic [JR_COND_W-1:0] {
        JC_ALWAYS = 4'd0,
        JC_EQ     = 4'd1,
        JC_NE     = 4'd2,
        JC_HS     = 4'd3,
        JC_LO     = 4'd4,
        JC_MI     = 4'd5,
        JC_PL     = 4'd6,
        JC_VS     = 4'd7,
        JC_VC     = 4'd8,
        JC_GE     = 4'd9,
        JC_LT     = 4'd10
    } jr_cond_e;

    localparam int JR_LAST = 10;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } jr_flags_t;

    // Returns 1 when the condition numbered code holds for flags f.
    function automatic logic jr_holds(input int code, input jr_flags_t f);
        case (code)
            0:       return 1'b1;
            1:       return f.z;
            2:       return !f.z;
            3:       return f.c;
            4:       return !f.c;
            5:       return f.n;
            6:       return !f.n;
            7:       return f.v;
            8:       return !f.v;
            9:       return f.n == f.v;
            10:      return f.n != f.v;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/jr_cond_eval.sv
// Module: jr_cond_eval
// Evaluates every selector code in parallel against the flags, then picks
// the one named by sel. Purely combinational in its datapath; clk and rst_n
// only clock the assertions. Assumes sel is stable during the cycle.
module jr_cond_eval
    import jr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [JR_COND_W-1:0] sel,
    input  jr_flags_t            flags,
    output logic                 hit
);
    logic [JR_NCODES-1:0] code_true;

    // One evaluator per code; unused codes tie off to never-taken.
    for (genvar gi = 0; gi < JR_NCODES; gi++) begin : g_code
        if (gi <= JR_LAST) begin : g_used
            assign code_true[gi] = jr_holds(gi, flags);
        end else begin : g_unused
            assign code_true[gi] = 1'b0;
        end
    end

    // Select the requested code and gate with jump-valid.
    always_comb begin
        hit = valid & code_true[sel];
    end

    // R2: no jump presented means not taken.
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !hit);
    // R3: the always code takes every valid jump.
    p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sel == JC_ALWAYS) |-> hit);
    // R9: unused codes never fire.
    p_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel > 4'(JR_LAST)) |-> !hit);
    // R8: signed greater-or-equal follows N == V.
    p_ge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sel == JC_GE) |-> (hit == (flags.n == flags.v)));
    // R8: signed less-than is the complement of greater-or-equal.
    p_lt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sel == JC_LT) |-> (hit != (flags.n == flags.v)));
endmodule

// File: rtl/jr_pc_reg.sv
// Module: jr_pc_reg
// Holds the program counter. On an update cycle it chooses between the
// target and the sequential address; otherwise it keeps its value.
// Assumes a synchronous active-low reset that loads RESET_VEC.
module jr_pc_reg #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              use_target,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic [ADDR_W-1:0] pc_nxt,
    output logic [ADDR_W-1:0] pc_q
);
    // Next-address mux: target, sequential or hold.
    always_comb begin
        if (!upd_en)        pc_nxt = pc_q;
        else if (use_target) pc_nxt = tgt_addr;
        else                pc_nxt = seq_addr;
    end

    // PC register with synchronous reset to the reset vector.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_VEC;
        else        pc_q <= pc_nxt;
    end

    // R2: idle cycles leave the PC unchanged.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(pc_q));
    // R10: a taken jump lands on the target.
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && use_target) |=> pc_q == $past(tgt_addr));
    // R10: a jump not taken falls through to the sequential address.
    p_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !use_target) |=> pc_q == $past(seq_addr));
endmodule

// File: rtl/jump_resolver.sv
// Module: jump_resolver (top)
// Decides whether a presented jump is taken from the status flags and the
// selector code, and advances the program counter accordingly. Assumes the
// flags are already valid for the cycle in which jmp_valid is high.
module jump_resolver #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jmp_valid,
    input  logic [3:0]        jmp_cond,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic [ADDR_W-1:0] jmp_target,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] pc_q
);
    import jr_pkg::*;

    jr_flags_t flags;

    // Pack the flag pins into the shared struct.
    always_comb begin
        flags = '{z: flag_z, c: flag_c, n: flag_n, v: flag_v};
    end

    jr_cond_eval u_eval (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (jmp_valid),
        .sel   (jmp_cond),
        .flags (flags),
        .hit   (taken)
    );

    jr_pc_reg #(
        .ADDR_W    (ADDR_W),
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (jmp_valid),
        .use_target (taken),
        .seq_addr   (seq_pc),
        .tgt_addr   (jmp_target),
        .pc_nxt     (next_pc),
        .pc_q       (pc_q)
    );
endmodule

// File: tb/jump_resolver_bench.sv
module jump_resolver_bench;
    localparam int AW = 12;
    localparam logic [AW-1:0] RV = 12'hA5C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic jmp_valid = 1'b0;
    logic [3:0] jmp_cond = '0;
    logic flag_z = 0, flag_c = 0, flag_n = 0, flag_v = 0;
    logic [AW-1:0] seq_pc = '0, jmp_target = '0;
    logic taken;
    logic [AW-1:0] next_pc, pc_q;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct { logic [AW-1:0] pc; string req; } exp_t;
    exp_t sb[$];
    logic [AW-1:0] model_pc;

    always #2 clk = ~clk;

    jump_resolver #(.ADDR_W(AW), .RESET_VEC(RV)) u_jump_resolver (
        .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_cond(jmp_cond),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
        .seq_pc(seq_pc), .jmp_target(jmp_target),
        .taken(taken), .next_pc(next_pc), .pc_q(pc_q));

    // Expected outcome written from the requirement list.
    function automatic bit want(input int c, input bit z, cy, n, v);
        case (c)
            0: return 1;             // R3
            1: return z;             // R4
            2: return !z;            // R4
            3: return cy;            // R5
            4: return !cy;           // R5
            5: return n;             // R6
            6: return !n;            // R6
            7: return v;             // R7
            8: return !v;            // R7
            9: return n == v;        // R8
            10: return n != v;       // R8
            default: return 0;       // R9
        endcase
    endfunction

    function automatic string req_name(input int c);
        case (c)
            0: return "R3";
            1, 2: return "R4";
            3, 4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            9, 10: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check taken, queue expected PC.
    task automatic drive(input bit vld, input int c, input logic [3:0] f,
                         input logic [AW-1:0] sq, tg);
        bit exp_tk;
        @(negedge clk);
        jmp_valid = vld; jmp_cond = 4'(c);
        {flag_z, flag_c, flag_n, flag_v} = f;
        seq_pc = sq; jmp_target = tg;
        #1;
        exp_tk = vld && want(c, f[3], f[2], f[1], f[0]);
        check(vld ? req_name(c) : "R2", AW'(taken), AW'(exp_tk));
        if (vld) model_pc = exp_tk ? tg : sq;
        check("R10", next_pc, model_pc);
        sb.push_back('{pc: model_pc, req: vld ? "R10" : "R2"});
    endtask

    // Monitor: after each edge, compare registered PC with the queue head.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, pc_q, e.pc);
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 check("R1", pc_q, RV);
        model_pc = RV;
        @(negedge clk) rst_n = 1;
        // R2: idle with an always code and fresh addresses: PC stays at reset vector.
        drive(0, 0, 4'hF, 12'h111, 12'h222);
        drive(0, 3, 4'h4, 12'h333, 12'h444);
        // Sweep every code against every flag pattern.
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive(1, c, 4'(f), 12'(12'h100 + c * 16 + f), 12'(12'h800 + c * 16 + f));
                if (f == 7) drive(0, 0, 4'hF, 12'h0F0, 12'h0E0); // R2 hold
            end
        end
        // R1: reset mid-run returns PC to the vector.
        @(negedge clk);
        jmp_valid = 1; jmp_cond = 0; jmp_target = 12'h123;
        rst_n = 0;
        @(posedge clk); #1 check("R1", pc_q, RV);
        @(negedge clk); rst_n = 1; jmp_valid = 0;
        repeat (3) @(posedge clk);
        #1 check("R2", pc_q, RV);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule